// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block takes the six destination address bytes at the head of a received Ethernet frame and decides whether the frame is kept. Four rules apply in a fixed priority. Promiscuous mode keeps everything. An all-ones destination is a broadcast and follows its own enable. A group address (bit 0 of the first byte set) is looked up in a 64-bit hash table. Any other address must equal the programmed station address exactly. The hash index comes from a CRC-32 that a bit-serial engine computes over the address, one bit per clock.

The receive configuration byte, the station address and the hash table are static register inputs. They must hold steady from the start strobe until the done strobe. The first byte arrives with `start_i` and the other five follow on the next five clocks. Exactly 49 clocks after the start edge a one-cycle `done_o` pulse appears together with the verdict on `accept_o`. The verdict then stays unchanged until the next start.

The controller is a three-state machine. ST_IDLE waits and moves to ST_SHIFT on a start. ST_SHIFT feeds one address bit per clock into the CRC. After the 48th bit it moves to ST_LOOKUP. ST_LOOKUP registers the decision, raises done and returns to ST_IDLE. A start in any state, ST_SHIFT and ST_LOOKUP included, forces the machine into ST_SHIFT with a freshly seeded CRC.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `accept_o` and `done_o` are both 0.
- R2: When `rx_cfg_i` bit 4 is 1, every frame is accepted, whatever its address, the table and the station address.
- R3: With bit 4 clear, a destination of all ones (FF in every byte) is accepted exactly when `rx_cfg_i` bit 2 is 1. Bit 3, the table and the station address have no effect on it.
- R4: With bit 4 clear, a destination that is not all ones but has bit 0 of its first byte set is accepted only when `rx_cfg_i` bit 3 is 1 and the selected hash table bit is 1.
- R5: The CRC is seeded to all ones. Bytes are taken first to last, each least significant bit first. For each bit, f = CRC[31] XOR data. The CRC shifts left by one, and when f is 1 it is XORed with 0x04C11DB6 and then has bit 0 set.
- R6: The hash index h is CRC bits 31 to 26 after all 48 bits. h[5:3] picks table byte n, which sits at `mcast_tbl_i` bits 8n+7..8n. h[2:0] picks the bit inside that byte.
- R7: Any other destination is accepted only when all six bytes equal `station_i`, where address byte k (k = 0 is the first byte received) is compared with `station_i` bits 8k+7..8k.
- R8: Byte 0 is taken with `start_i` and bytes 1 to 5 on the next five clocks. `done_o` is a one-cycle pulse that is high during the 49th cycle after the start edge and low in all earlier cycles.
- R9: A start strobe clears `accept_o` to 0 on the next edge. Otherwise `accept_o` changes only at the edge that raises `done_o` and is held after it.
- R10: A start strobe that arrives while a decision is in progress, including the cycle in which the old result would have been registered, discards the old decision: no done pulse for it appears, and the new result follows the timing of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of a new address; qualifies byte 0 |
| byte_i | input | 8 | Address byte stream |
| rx_cfg_i | input | 8 | Receive configuration: bit 2 broadcast, bit 3 group, bit 4 promiscuous |
| station_i | input | 48 | Station address, byte k at bits 8k+7..8k |
| mcast_tbl_i | input | 64 | Hash table, byte n at bits 8n+7..8n |
| accept_o | output | 1 | Verdict, valid from the done pulse until the next start |
| done_o | output | 1 | One-cycle pulse when a verdict is registered |

## Verification
A new start strobe can land in the same cycle in which the machine is about to register a verdict and raise done, so a restart and a result can fall on one edge. The bench provokes this by issuing the second address's start exactly on the edge of the first address's ST_LOOKUP cycle, and also twenty cycles into a computation. It judges the outcome at the pins: no done pulse may appear for the abandoned address, `accept_o` must read 0 right after the restart, and the second address's verdict must arrive 49 cycles after its own start.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LOOKUP = 2'd2
    } flt_state_e;

    // Receive configuration bit positions
    localparam int CFG_BCAST   = 2;
    localparam int CFG_MCAST   = 3;
    localparam int CFG_PROMISC = 4;

endpackage

// File: rtl/dafilt_crc_serial.sv
module dafilt_crc_serial #(
    parameter int unsigned           CRC_W = 32,
    parameter logic [CRC_W-1:0]      POLY  = 32'h04C11DB6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             init_i,
    input  logic             step_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] shifted;
    logic             feedback;

    always_comb begin
        feedback = crc_q[CRC_W-1] ^ bit_i;
        shifted  = {crc_q[CRC_W-2:0], 1'b0};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            crc_q <= '1;
        end else if (init_i) begin
            crc_q <= '1;
        end else if (step_i) begin
            crc_q <= feedback ? ((shifted ^ POLY) | CRC_W'(1)) : shifted;
        end
    end

    assign crc_o = crc_q;

    AST_CRC_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> (crc_o == '1)); // R5
    AST_CRC_FB_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !init_i && (crc_o[CRC_W-1] ^ bit_i)) |=> crc_o[0]); // R5
    AST_CRC_FB_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !init_i && !(crc_o[CRC_W-1] ^ bit_i)) |=> !crc_o[0]); // R5

endmodule

// File: rtl/dafilt_addr_capture.sv
module dafilt_addr_capture #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned N_BYTES = 6,
    parameter int unsigned SEL_W   = 6
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic                      load_en_i,
    input  logic [SEL_W-1:0]          load_sel_i,
    input  logic [BYTE_W-1:0]         byte_i,
    output logic [N_BYTES*BYTE_W-1:0] addr_o
);

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        logic              take;

        if (g == 0) begin : g_first
            // First byte travels with the start strobe
            assign take = start_i;
        end else begin : g_rest
            // Byte g arrives g cycles after the start edge
            assign take = !start_i && load_en_i && (load_sel_i == SEL_W'(g - 1));
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                byte_q <= '0;
            end else if (take) begin
                byte_q <= byte_i;
            end
        end

        assign addr_o[g*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify
    import dafilt_pkg::*;
#(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned HASH_W = 6,
    parameter int unsigned CFG_W  = 8
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [HASH_W-1:0]     hash_i,
    input  logic [CFG_W-1:0]      cfg_i,
    input  logic [ADDR_W-1:0]     station_i,
    input  logic [2**HASH_W-1:0]  table_i,
    output logic                  accept_o
);

    logic is_bcast;
    logic is_group;
    logic tbl_hit;
    logic uni_hit;

    always_comb begin
        is_bcast = &addr_i;
        is_group = addr_i[0];
        // Upper index bits choose the byte, lower three the bit in it;
        // with bytes packed little-end first this is a flat bit index.
        tbl_hit  = table_i[hash_i];
        uni_hit  = (addr_i == station_i);

        if (cfg_i[CFG_PROMISC]) begin
            accept_o = 1'b1;
        end else if (is_bcast) begin
            accept_o = cfg_i[CFG_BCAST];
        end else if (is_group) begin
            accept_o = cfg_i[CFG_MCAST] && tbl_hit;
        end else begin
            accept_o = uni_hit;
        end
    end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import dafilt_pkg::*;
#(
    parameter int unsigned          BYTE_W     = 8,
    parameter int unsigned          ADDR_BYTES = 6,
    parameter int unsigned          CRC_W      = 32,
    parameter logic [CRC_W-1:0]     CRC_POLY   = 32'h04C11DB6,
    parameter int unsigned          HASH_W     = 6,
    parameter int unsigned          CFG_W      = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         start_i,
    input  logic [BYTE_W-1:0]            byte_i,
    input  logic [CFG_W-1:0]             rx_cfg_i,
    input  logic [BYTE_W*ADDR_BYTES-1:0] station_i,
    input  logic [2**HASH_W-1:0]         mcast_tbl_i,
    output logic                         accept_o,
    output logic                         done_o
);

    localparam int unsigned ADDR_W  = BYTE_W * ADDR_BYTES;
    localparam int unsigned CNT_W   = $clog2(ADDR_W);
    localparam int unsigned LAST    = ADDR_W - 1;
    localparam int unsigned LATENCY = ADDR_W + 1;

    flt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc;
    logic              verdict;
    logic              in_shift;

    assign in_shift = (state_q == ST_SHIFT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SHIFT;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SHIFT:  if (bit_cnt_q == CNT_W'(LAST)) state_d = ST_LOOKUP;
                ST_LOOKUP: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register and bit counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                bit_cnt_q <= '0;
            end else if (in_shift) begin
                bit_cnt_q <= (bit_cnt_q == CNT_W'(LAST)) ? '0 : bit_cnt_q + CNT_W'(1);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            accept_o <= 1'b0;
            done_o   <= 1'b0;
        end else if (start_i) begin
            accept_o <= 1'b0;
            done_o   <= 1'b0;
        end else if (state_q == ST_LOOKUP) begin
            accept_o <= verdict;
            done_o   <= 1'b1;
        end else begin
            done_o   <= 1'b0;
        end
    end

    dafilt_addr_capture #(
        .BYTE_W  (BYTE_W),
        .N_BYTES (ADDR_BYTES),
        .SEL_W   (CNT_W)
    ) i_capture (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .load_en_i  (in_shift),
        .load_sel_i (bit_cnt_q),
        .byte_i     (byte_i),
        .addr_o     (addr_q)
    );

    dafilt_crc_serial #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) i_crc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .init_i (start_i),
        .step_i (in_shift && !start_i),
        .bit_i  (addr_q[bit_cnt_q]),
        .crc_o  (crc)
    );

    dafilt_classify #(
        .ADDR_W (ADDR_W),
        .HASH_W (HASH_W),
        .CFG_W  (CFG_W)
    ) i_classify (
        .addr_i    (addr_q),
        .hash_i    (crc[CRC_W-1 -: HASH_W]),
        .cfg_i     (rx_cfg_i),
        .station_i (station_i),
        .table_i   (mcast_tbl_i),
        .accept_o  (verdict)
    );

    // Checker counter: edges since the most recent start
    localparam int unsigned CHK_W = $clog2(LATENCY + 3);
    logic [CHK_W-1:0] since_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= '0;
        end else if (start_i) begin
            since_q <= CHK_W'(1);
        end else if (since_q != '0 && since_q < CHK_W'(LATENCY + 2)) begin
            since_q <= since_q + CHK_W'(1);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R8
    AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (since_q == CHK_W'(LATENCY + 1))); // R8
    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (!done_o && !accept_o)); // R10
    AST_ACCEPT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && state_q != ST_LOOKUP) |=> $stable(accept_o)); // R9
    AST_PROMISC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOOKUP && !start_i && rx_cfg_i[CFG_PROMISC]) |=> (accept_o && done_o)); // R2
    AST_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOOKUP && !start_i && !rx_cfg_i[CFG_PROMISC] && (&addr_q))
        |=> (accept_o == $past(rx_cfg_i[CFG_BCAST]))); // R3

endmodule

// File: tb/test_dest_addr_filter.sv
`timescale 1ns/1ps
module test_dest_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [7:0]  cfg = '0;
    logic [47:0] sta = '0;
    logic [63:0] tbl = '0;
    logic        accept;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_seen = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dest_addr_filter i_dest_addr_filter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .byte_i      (byte_in),
        .rx_cfg_i    (cfg),
        .station_i   (sta),
        .mcast_tbl_i (tbl),
        .accept_o    (accept),
        .done_o      (done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Hash index from the CRC rule (R5, R6)
    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c;
        logic        f;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                f = c[31] ^ a[8*k + j];
                c = c << 1;
                if (f) c = (c ^ 32'h04C11DB6) | 32'd1;
            end
        end
        return c[31:26];
    endfunction

    // Present six bytes; called at a falling edge, returns at a falling edge
    task automatic send(input logic [47:0] a);
        done_seen = 1'b0;
        start   = 1'b1;
        byte_in = a[7:0];
        for (int k = 1; k < 6; k++) begin
            @(negedge clk);
            if (done) done_seen = 1'b1;
            start   = 1'b0;
            byte_in = a[8*k +: 8];
        end
    endtask

    task automatic wait_result(input bit exp, input string tag);
        bit early;
        early = 1'b0;
        for (int k = 0; k < 44; k++) begin
            @(negedge clk);
            if (done) early = 1'b1;
        end
        check(!early, {tag, " R8 no early done"}, early, 0);
        @(negedge clk);
        check(done == 1'b1, {tag, " R8 done at 49"}, done, 1);
        check(accept == exp, tag, accept, exp);
    endtask

    task automatic run(input logic [47:0] a, input logic [7:0] c, input logic [47:0] s,
                       input logic [63:0] t, input bit exp, input string tag);
        cfg = c;
        sta = s;
        tbl = t;
        send(a);
        wait_result(exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        logic [47:0] a;
        logic [47:0] s;
        logic [5:0]  h;
        bit          e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(accept == 1'b0 && done == 1'b0, "R1 reset outputs", {accept, done}, 0);

        // R3: broadcast across every combination of the three mode bits
        for (int c = 0; c < 8; c++) begin
            e = c[2] | c[0];
            run(48'hFFFF_FFFF_FFFF, {3'b000, c[2], c[1], c[0], 2'b00}, 48'hFFFF_FFFF_FFFF,
                '1, e, "R3 broadcast mode sweep");
        end

        // R4 R5 R6: group addresses over all 64 generated patterns
        for (int i = 0; i < 64; i++) begin
            a = {8'(i * 37 + 5), 8'(i * 13), 8'(i * 7 + 1), 8'(i), 8'(i * 3), 8'((i << 1) | 1)};
            h = hash_of(a);
            run(a, 8'h08, 48'h0, 64'd1 << h, 1'b1, "R6 R5 selected table bit set");
            run(a, 8'h08, 48'h0, ~(64'd1 << h), 1'b0, "R6 R5 only selected bit clear");
            if (i % 8 == 0) begin
                run(a, 8'h04, a, '1, 1'b0, "R4 group disabled");
            end
        end

        // R7: unicast exact match and single-byte mismatches
        s = 48'h5A4B_3C2D_1E02;
        run(s, 8'h00, s, '0, 1'b1, "R7 exact match");
        run(s, 8'h0C, s, '1, 1'b1, "R7 exact match other modes on");
        for (int k = 0; k < 6; k++) begin
            run(s ^ (48'h02 << (8 * k)), 8'h0C, s, '1, 1'b0, "R7 one byte differs");
        end

        // R2: promiscuous overrides mismatch and empty table
        run(s ^ 48'h04, 8'h10, s, '0, 1'b1, "R2 promisc unicast mismatch");
        run(48'h0000_0000_0001, 8'h10, s, '0, 1'b1, "R2 promisc group empty table");
        run(48'hFFFF_FFFF_FFFF, 8'h10, s, '0, 1'b1, "R2 promisc broadcast disabled");

        // R9: verdict held while inputs change and no start arrives
        run(s, 8'h00, s, '0, 1'b1, "R9 setup");
        cfg = 8'h00;
        sta = ~s;
        byte_in = 8'hAA;
        repeat (10) @(negedge clk);
        check(accept == 1'b1 && done == 1'b0, "R9 verdict held", {accept, done}, 2'b10);

        // R10: restart twenty cycles into a computation
        cfg = 8'h00;
        sta = s;
        send(s);
        repeat (15) @(negedge clk);
        send(s ^ 48'h0100);
        check(accept == 1'b0, "R9 start clears accept", accept, 0);
        wait_result(1'b0, "R10 mid restart new verdict");

        // R10: restart on the very edge where the old verdict would register
        run(s, 8'h00, s, '0, 1'b1, "R10 setup");
        send(s);
        repeat (44) @(negedge clk);
        send(s ^ 48'h0200);
        check(!done_seen, "R10 no done for abandoned", done_seen, 0);
        check(accept == 1'b0, "R10 accept cleared by restart", accept, 0);
        wait_result(1'b0, "R10 lookup collision new verdict");

        // R8: back-to-back frames, second started right after done
        run(s, 8'h00, s, '0, 1'b1, "R8 back to back first");
        run(48'hFFFF_FFFF_FFFF, 8'h04, s, '0, 1'b1, "R8 back to back second");

        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", done, 0);
        wrap_up();
    end

endmodule